// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Overflow Trap

This block is the arithmetic and logic unit of a 32-bit integer core. Each cycle it may accept one operation, given as two operands, a four-bit operation code, a signed/unsigned qualifier and the address of the instruction issuing it. One clock edge later it presents the result, a destination write-enable, four condition flags (sign, zero, carry, low-byte parity), a non-trapping unsigned-carry indication, a trap request and the exception address register.

Signed addition and subtraction check for two's-complement overflow. When overflow is found, the block raises a trap request, suppresses the destination write, and loads the exception address register with the address of the offending instruction. Unsigned forms never trap. Compare and test update the flags but never write the destination. The register file, branch decisions and trap vectoring are outside the block.

Top module: `alu32_trap`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, all outputs are zero, including `epc`.
- R2: Operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 NOR, 5 shift left, 6 shift right, 7 compare, 8 test. A result is presented with `out_valid` high one clock edge after `in_valid` is sampled high. Subtract computes a + (~b + 1).
- R3: A signed add overflows when both operands have the same sign and the result sign differs from it. A signed subtract overflows when the operand signs differ and the result sign differs from that of `a`. Each overflow raises `trap_req` for that result only.
- R4: When `trap_req` is high, `wr_en` is low and `epc` equals the `pc` of the faulting operation. `epc` keeps its value in every other cycle.
- R5: With `is_signed` low, no operation traps. An unsigned add whose carry out of bit 31 is 1 raises `uovf` for that result. `uovf` is low in all other cases, including signed operations.
- R6: AND, OR and NOR give the bitwise results and assert `wr_en`.
- R7: The shift operations are logical. They shift `a` by `b[4:0]` and ignore `b[31:5]`.
- R8: Compare produces the subtract result and flags, and test produces the AND result and flags. Both keep `wr_en` low and never trap.
- R9: `flag_s` is result bit 31, and `flag_z` is set when the result is zero. `flag_p` is set when result bits [7:0] hold an even number of ones. `flag_c` is the carry out of bit 31 for add, subtract and compare, and 0 for all other operations.
- R10: Codes 9 to 15 give result 0 with `wr_en`, `trap_req` and `uovf` low and `epc` unchanged. The flags follow R9 for a zero result.
- R11: When no operation is sampled, `out_valid`, `wr_en`, `trap_req` and `uovf` are low in the next cycle. The result and flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| is_signed | input | 1 | Signed form of add/subtract (may trap) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand / shift amount |
| pc | input | 32 | Address of the issuing instruction |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write-enable |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_p | output | 1 | Even parity of result bits [7:0] |
| uovf | output | 1 | Unsigned add carried out, no trap |
| trap_req | output | 1 | Signed overflow exception request |
| epc | output | 32 | Exception address register |

## Verification
Every output belongs to the operation sampled on the previous rising edge, so each result is due exactly one cycle after its stimulus. The driver applies inputs on the falling edge and places the expected values for that operation in a queue. On the following falling edge the monitor finds `out_valid` high and compares every output against the front of the queue, `epc` included. Idle gaps are checked in the same way: outputs must drop `out_valid`, the strobes must be low, and `epc` must hold its value.

// File: rtl/alu32_trap.sv
module alu32_trap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] pc,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         flag_s,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_p,
  output logic         uovf,
  output logic         trap_req,
  output logic [W-1:0] epc
);
  localparam int SHW = $clog2(W);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2,
                         OP_OR  = 4'd3, OP_NOR = 4'd4, OP_SLL = 4'd5,
                         OP_SRL = 4'd6, OP_CMP = 4'd7, OP_TST = 4'd8;

  logic         negate;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic         ovf_s;

  assign negate = (op == OP_SUB) || (op == OP_CMP);
  assign b_eff  = negate ? ~b : b;
  assign sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, negate};
  assign ovf_s  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

  logic [W-1:0] res_n;
  logic         cy_n, wr_n, trap_n, uovf_n;

  always_comb begin
    res_n  = '0;
    cy_n   = 1'b0;
    wr_n   = 1'b0;
    trap_n = 1'b0;
    uovf_n = 1'b0;
    unique case (op)
      OP_ADD: begin
        res_n  = sum[W-1:0];
        cy_n   = sum[W];
        trap_n = is_signed && ovf_s;
        uovf_n = !is_signed && sum[W];
        wr_n   = !trap_n;
      end
      OP_SUB: begin
        res_n  = sum[W-1:0];
        cy_n   = sum[W];
        trap_n = is_signed && ovf_s;
        wr_n   = !trap_n;
      end
      OP_CMP: begin
        res_n = sum[W-1:0];
        cy_n  = sum[W];
      end
      OP_AND: begin res_n = a & b;    wr_n = 1'b1; end
      OP_OR:  begin res_n = a | b;    wr_n = 1'b1; end
      OP_NOR: begin res_n = ~(a | b); wr_n = 1'b1; end
      OP_SLL: begin res_n = a << b[SHW-1:0]; wr_n = 1'b1; end
      OP_SRL: begin res_n = a >> b[SHW-1:0]; wr_n = 1'b1; end
      OP_TST: res_n = a & b;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flag_s    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_p    <= 1'b0;
      uovf      <= 1'b0;
      trap_req  <= 1'b0;
      epc       <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && wr_n;
      uovf      <= in_valid && uovf_n;
      trap_req  <= in_valid && trap_n;
      if (in_valid) begin
        result <= res_n;
        flag_s <= res_n[W-1];
        flag_z <= (res_n == '0);
        flag_c <= cy_n;
        flag_p <= ~^res_n[7:0];
        if (trap_n) epc <= pc;
      end
    end
  end
endmodule

module alu32_trap_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         is_signed,
  input logic [W-1:0] pc,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         flag_z,
  input logic         flag_p,
  input logic         trap_req,
  input logic         uovf,
  input logic [W-1:0] epc
);
  a_r3_trap_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> out_valid);
  a_r4_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !wr_en);
  a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> epc == $past(pc));
  a_r4_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> $stable(epc));
  a_r5_unsigned_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !is_signed) |-> !trap_req);
  a_r5_uovf_excl_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !(uovf && trap_req));
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> flag_z == (result == '0));
  a_r9_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> flag_p == ~^result[7:0]);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wr_en && !uovf && !trap_req);
endmodule

bind alu32_trap alu32_trap_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_signed(is_signed),
  .pc(pc), .out_valid(out_valid), .result(result), .wr_en(wr_en),
  .flag_z(flag_z), .flag_p(flag_p), .trap_req(trap_req), .uovf(uovf),
  .epc(epc)
);

// File: tb/tb_alu32_trap.sv
module tb_alu32_trap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        is_signed = 1'b0;
  logic [31:0] a = '0, b = '0, pc = '0;
  logic        out_valid, wr_en, flag_s, flag_z, flag_c, flag_p, uovf, trap_req;
  logic [31:0] result, epc;

  always #5 clk = ~clk;

  alu32_trap dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .is_signed(is_signed), .a(a), .b(b), .pc(pc), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .flag_s(flag_s), .flag_z(flag_z),
    .flag_c(flag_c), .flag_p(flag_p), .uovf(uovf), .trap_req(trap_req),
    .epc(epc)
  );

  typedef struct {
    logic [31:0] res;
    logic        we, s, z, c, p, uo, tr;
    logic [31:0] epc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic [31:0] m_epc = '0;
  logic [31:0] last_res = '0;
  logic [4:0]  last_flags = '0;

  function automatic exp_t model(input logic [3:0] o, input logic sg,
                                 input logic [31:0] x, input logic [31:0] y,
                                 input logic [31:0] ipc, input string tag);
    exp_t e;
    logic [32:0] t;
    logic        ov;
    e.res = '0; e.we = 0; e.c = 0; e.uo = 0; e.tr = 0; e.tag = tag;
    case (o)
      4'd0: begin
        t = {1'b0, x} + {1'b0, y};
        e.res = t[31:0]; e.c = t[32];
        ov = (x[31] == y[31]) && (t[31] != x[31]);
        e.tr = sg && ov; e.uo = !sg && t[32]; e.we = !e.tr;
      end
      4'd1, 4'd7: begin
        t = {1'b0, x} + {1'b0, ~y} + 33'd1;
        e.res = t[31:0]; e.c = t[32];
        ov = (x[31] != y[31]) && (t[31] != x[31]);
        e.tr = (o == 4'd1) && sg && ov; e.we = (o == 4'd1) && !e.tr;
      end
      4'd2: begin e.res = x & y; e.we = 1; end
      4'd3: begin e.res = x | y; e.we = 1; end
      4'd4: begin e.res = ~(x | y); e.we = 1; end
      4'd5: begin e.res = x << y[4:0]; e.we = 1; end
      4'd6: begin e.res = x >> y[4:0]; e.we = 1; end
      4'd8: e.res = x & y;
      default: ;
    endcase
    e.s = e.res[31];
    e.z = (e.res == 0);
    e.p = ~^e.res[7:0];
    return e;
  endfunction

  task automatic apply(input logic [3:0] o, input logic sg, input logic [31:0] x,
                       input logic [31:0] y, input logic [31:0] ipc, input string tag);
    exp_t e;
    @(negedge clk);
    op = o; is_signed = sg; a = x; b = y; pc = ipc; in_valid = 1'b1;
    e = model(o, sg, x, y, ipc, tag);
    if (e.tr) m_epc = ipc;
    e.epc = m_epc;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = 32'hDEAD_BEEF; b = 32'h1; op = 4'd0; is_signed = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      logic bad;
      bad = 0;
      n_vec++;
      if (sb.size() == 0) begin
        $display("FAIL R2 unexpected result: actual out_valid=1 expected out_valid=0");
        n_bad++;
      end else begin
        e = sb.pop_front();
        if (result !== e.res) begin bad = 1;
          $display("FAIL %s result: actual %h expected %h", e.tag, result, e.res); end
        if (wr_en !== e.we) begin bad = 1;
          $display("FAIL %s wr_en: actual %b expected %b", e.tag, wr_en, e.we); end
        if ({flag_s, flag_z, flag_c, flag_p} !== {e.s, e.z, e.c, e.p}) begin bad = 1;
          $display("FAIL %s R9 flags szcp: actual %b expected %b", e.tag,
                   {flag_s, flag_z, flag_c, flag_p}, {e.s, e.z, e.c, e.p}); end
        if (uovf !== e.uo) begin bad = 1;
          $display("FAIL %s R5 uovf: actual %b expected %b", e.tag, uovf, e.uo); end
        if (trap_req !== e.tr) begin bad = 1;
          $display("FAIL %s R3 trap_req: actual %b expected %b", e.tag, trap_req, e.tr); end
        if (epc !== e.epc) begin bad = 1;
          $display("FAIL %s R4 epc: actual %h expected %h", e.tag, epc, e.epc); end
        if (bad) n_bad++;
        last_res = e.res;
        last_flags = {e.s, e.z, e.c, e.p, 1'b0};
      end
    end else if (rst_n) begin
      if (wr_en || trap_req || uovf || epc !== m_epc || result !== last_res ||
          {flag_s, flag_z, flag_c, flag_p, 1'b0} !== last_flags) begin
        n_bad++;
        $display("FAIL R11 idle: actual we=%b tr=%b uo=%b epc=%h res=%h expected 0 0 0 %h %h",
                 wr_en, trap_req, uovf, epc, result, m_epc, last_res);
      end
    end
  end

  initial begin
    #2_000_000;
    $display("FAIL watchdog expired: actual running expected finished");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if ({out_valid, wr_en, flag_s, flag_z, flag_c, flag_p, uovf, trap_req} !== 8'h00 ||
        result !== 0 || epc !== 0) begin
      n_bad++;
      $display("FAIL R1 reset: actual res=%h epc=%h valid=%b expected zeros", result, epc, out_valid);
    end
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 0 || epc !== 0 || result !== 0) begin
      n_bad++;
      $display("FAIL R1 post-reset: actual valid=%b epc=%h expected 0 0", out_valid, epc);
    end

    apply(4'd0, 1, 32'd5, 32'd6, 32'h100, "R2 add");
    apply(4'd1, 1, 32'd12, 32'd5, 32'h104, "R2 sub");
    apply(4'd1, 0, 32'd5, 32'd12, 32'h108, "R2 sub borrow");
    apply(4'd0, 1, 32'h7FFF_FFFF, 32'd1, 32'h10C, "R3 add pos ovf");
    apply(4'd0, 0, 32'h7FFF_FFFF, 32'd1, 32'h110, "R5 unsigned no trap");
    apply(4'd0, 0, 32'hFFFF_FFFF, 32'd1, 32'h114, "R5 unsigned carry");
    apply(4'd0, 1, 32'h8000_0000, 32'h8000_0000, 32'h118, "R3 add neg ovf");
    apply(4'd0, 1, 32'h7FFF_FFFF, 32'h8000_0000, 32'h11C, "R3 add mixed signs");
    apply(4'd1, 1, 32'h8000_0000, 32'd1, 32'h120, "R3 sub neg ovf");
    apply(4'd1, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h124, "R3 sub pos ovf");
    apply(4'd1, 1, 32'd5, 32'hFFFF_FFFD, 32'h128, "R3 sub no ovf");
    apply(4'd1, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h12C, "R3 sub same sign");
    apply(4'd1, 0, 32'h8000_0000, 32'd1, 32'h130, "R5 unsigned sub no trap");
    idle(2);
    apply(4'd2, 0, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h200, "R6 and");
    apply(4'd3, 1, 32'hF000_0000, 32'h0000_000F, 32'h204, "R6 or");
    apply(4'd4, 0, 32'h0000_0000, 32'h0000_0000, 32'h208, "R6 nor");
    apply(4'd5, 0, 32'h0000_00F1, 32'h0000_0024, 32'h20C, "R7 sll upper b ignored");
    apply(4'd6, 0, 32'h8000_0000, 32'd31, 32'h210, "R7 srl");
    apply(4'd5, 0, 32'h1234_5678, 32'hFFFF_FFE0, 32'h214, "R7 sll zero amount");
    apply(4'd7, 1, 32'd77, 32'd77, 32'h218, "R8 cmp equal");
    apply(4'd7, 1, 32'h8000_0000, 32'd1, 32'h21C, "R8 cmp no trap");
    apply(4'd8, 0, 32'hFF00_0000, 32'h00FF_FFFF, 32'h220, "R8 test zero");
    apply(4'd8, 0, 32'h0000_0003, 32'h0000_0007, 32'h224, "R8 test");
    apply(4'd9, 1, 32'h7FFF_FFFF, 32'd1, 32'h228, "R10 unused op");
    apply(4'd15, 0, 32'hFFFF_FFFF, 32'd1, 32'h22C, "R10 unused op hi");
    idle(1);
    apply(4'd0, 1, 32'd3, 32'hFFFF_FFFD, 32'h300, "R9 add zero carry");
    apply(4'd3, 0, 32'h0000_0081, 32'd0, 32'h304, "R9 parity even");
    apply(4'd3, 0, 32'h0000_0100, 32'h0000_0001, 32'h308, "R9 parity odd");
    apply(4'd0, 1, 32'h4000_0000, 32'h4000_0000, 32'h30C, "R4 second trap");
    for (int i = 0; i < 8; i++)
      apply(4'(i % 9), 1'(i & 1), 32'h1357_9BDF * (i + 1), 32'h0246_8ACE ^ (i * 7),
            32'h400 + 32'(i * 4), "R2 mixed");
    idle(3);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule